// File: doc/BRIEF.md
# Narrow-bus SRAM word assembler

This block sits between a byte-wide host data bus and a 4096-word by 16-bit memory. The memory is built from two byte-wide halves, one for the upper byte and one for the lower byte. Each half is divided into four banks of 1024 words. The host first loads a 12-bit address register. It then moves each word in two byte transfers. A write sends the lower byte first. That byte waits in a data register. When the upper byte arrives, the block stores the complete 16-bit word into both halves in one cycle.

A read returns one byte of the addressed word, either the upper or the lower one as the host selects, one clock after the read strobe. Every memory access drives exactly one of four active-high bank selects. These are decoded from the top two address bits. When no access is in progress, all four are low. The memory arrays are behavioural and are part of the block.

Top module: `nbw_top`

## Requirements
- R1: After reset, `rd_vld` is 0, `rd_data` is 0, `bank_cs` is 0, and no lower byte is held, so a following upper-byte write stores nothing.
- R2: `addr_ld` loads `addr_in` into the address register. Bits [11:10] select the bank and bits [9:0] select the word within that bank. Words at the same offset in different banks are independent.
- R3: A write strobe with `byte_hi`=0 places `wr_data` in the data register and marks a lower byte as held. The memory is not changed and `bank_cs` stays 0.
- R4: A write strobe with `byte_hi`=1 while a lower byte is held stores {upper, lower} at the address loaded when the upper byte was taken. The store happens in the following cycle, and in that cycle `bank_cs` is one-hot on that address's bank. The held byte is then consumed.
- R5: A write strobe with `byte_hi`=1 when no lower byte is held is ignored. The memory is unchanged and no bank is selected.
- R6: A second lower-byte write before the upper byte replaces the held lower byte. The earlier half-built word is discarded.
- R7: A read strobe with `byte_hi`=1 returns bits [15:8] of the addressed word, and with `byte_hi`=0 it returns bits [7:0]. The data appears on `rd_data` with `rd_vld`=1 one clock later. `rd_vld` is high for exactly that one cycle per accepted read.
- R8: `bank_cs` has at most one bit set. It is non-zero only in a store cycle or a cycle with an accepted read strobe. In a read cycle the set bit is the bank of the address register.
- R9: A read strobe that falls in a store cycle is ignored. No `rd_vld` follows, and only the storing bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ld | input | 1 | Load the address register from `addr_in` |
| addr_in | input | 12 | Word address: bank in [11:10], offset in [9:0] |
| wr_stb | input | 1 | Byte write strobe |
| rd_stb | input | 1 | Byte read strobe |
| byte_hi | input | 1 | Byte select for the transfer: 1 = upper, 0 = lower |
| wr_data | input | 8 | Write byte from the host |
| rd_data | output | 8 | Registered read byte |
| rd_vld | output | 1 | `rd_data` is valid this cycle |
| bank_cs | output | 4 | One-hot bank select during an access |

## Verification
The hardest case to reach from the ports is a read strobe that lands in the single store cycle that follows an upper-byte write. The host never sees this cycle directly. The stimulus reaches it by counting falling edges: it raises `rd_stb` at the first falling edge after the upper byte was taken. At that point the only bank select must be the storing bank, and no read data may follow. A second hard case is a held lower byte that remains pending across reads and later writes. The bench drives lower bytes alone, a pair of lower bytes, and an upper byte with no lower byte before it. The scoreboard keeps its own copy of the pending byte, so the effect of each of these sequences is predicted.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // Choose one byte of a stored word; hi=1 gives the upper byte.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w, input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  // Join the two transferred bytes into one word.
  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi, input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/nbw_assembler.sv
module nbw_assembler
  import nbw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WORD_W-1:0] commit_word,
  output logic              pending
);
  logic [BYTE_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit      <= 1'b0;
      pending     <= 1'b0;
      lo_hold     <= '0;
      commit_addr <= '0;
      commit_word <= '0;
    end else begin
      commit <= 1'b0;
      if (wr_stb) begin
        if (!byte_hi) begin
          lo_hold <= wr_data;
          pending <= 1'b1;
        end else if (pending) begin
          commit      <= 1'b1;
          commit_addr <= addr_q;
          commit_word <= join_bytes(wr_data, lo_hold);
          pending     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/nbw_bank.sv
module nbw_bank
  import nbw_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << OFF_W;

  logic [BYTE_W-1:0] upper_mem [DEPTH];
  logic [BYTE_W-1:0] lower_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (sel && we) begin
      upper_mem[off] <= wdata[WORD_W-1:BYTE_W];
      lower_mem[off] <= wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (sel && !we) rdata <= {upper_mem[off], lower_mem[off]};
  end
endmodule

// File: rtl/nbw_top.sv
module nbw_top
  import nbw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_ld,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     wr_stb,
  input  logic                     rd_stb,
  input  logic                     byte_hi,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     rd_vld,
  output logic [(1<<BANK_W)-1:0]   bank_cs
);
  localparam int NBANK = 1 << BANK_W;
  localparam int OFF_W = ADDR_W - BANK_W;

  logic [ADDR_W-1:0] addr_q;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] commit_word;
  logic              pending;
  logic              rd_go;
  logic              access;
  logic [ADDR_W-1:0] acc_addr;
  logic [BANK_W-1:0] acc_bank;
  logic [OFF_W-1:0]  acc_off;
  logic [BANK_W-1:0] rd_bank_q;
  logic              rd_hi_q;
  logic [WORD_W-1:0] bank_rdata [NBANK];

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_ld) addr_q <= addr_in;
  end

  nbw_assembler #(.ADDR_W(ADDR_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .byte_hi(byte_hi),
    .wr_data(wr_data), .addr_q(addr_q), .commit(commit),
    .commit_addr(commit_addr), .commit_word(commit_word), .pending(pending)
  );

  // A store owns the memory for its cycle; a read strobe then is dropped.
  assign rd_go    = rd_stb && !commit;
  assign access   = commit || rd_go;
  assign acc_addr = commit ? commit_addr : addr_q;
  assign acc_bank = acc_addr[ADDR_W-1:OFF_W];
  assign acc_off  = acc_addr[OFF_W-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_cs[b] = access && (acc_bank == BANK_W'(b));
    nbw_bank #(.OFF_W(OFF_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .sel(bank_cs[b]), .we(commit),
      .off(acc_off), .wdata(commit_word), .rdata(bank_rdata[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld    <= 1'b0;
      rd_bank_q <= '0;
      rd_hi_q   <= 1'b0;
    end else begin
      rd_vld <= rd_go;
      if (rd_go) begin
        rd_bank_q <= acc_bank;
        rd_hi_q   <= byte_hi;
      end
    end
  end

  assign rd_data = pick_byte(bank_rdata[rd_bank_q], rd_hi_q);
endmodule

// File: rtl/nbw_checker.sv
module nbw_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic             byte_hi,
  input logic             rd_vld,
  input logic [NBANK-1:0] bank_cs,
  input logic             commit,
  input logic             pending
);
  // R8: never more than one bank selected
  a_r8_cs_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs));

  // R8: with no store and no read strobe no bank is selected
  a_r8_idle_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !rd_stb) |-> (bank_cs == '0));

  // R4: store cycle selects exactly one bank
  a_r4_store_cs: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($countones(bank_cs) == 1));

  // R4: upper byte with a held lower byte leads to a store next cycle
  a_r4_commit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && byte_hi && pending) |=> commit);

  // R5: upper byte with nothing held stores nothing
  a_r5_hi_alone_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && byte_hi && !pending) |=> !commit);

  // R7: accepted read gives valid data one clock later
  a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !commit) |=> rd_vld);

  // R9: read strobe in a store cycle yields no valid data
  a_r9_read_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && commit) |=> !rd_vld);

  // R3: a lower byte marks a word as half built
  a_r3_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !byte_hi) |=> pending);
endmodule

bind nbw_top nbw_checker #(.NBANK(1 << BANK_W)) u_nbw_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .byte_hi(byte_hi), .rd_vld(rd_vld), .bank_cs(bank_cs),
  .commit(commit), .pending(pending)
);

// File: tb/nbw_top_tb.sv
`timescale 1ns/1ps
module nbw_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_ld = 1'b0;
  logic [11:0] addr_in = '0;
  logic        wr_stb = 1'b0;
  logic        rd_stb = 1'b0;
  logic        byte_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_vld;
  logic [3:0]  bank_cs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nbw_top u_dut (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .byte_hi(byte_hi), .wr_data(wr_data),
    .rd_data(rd_data), .rd_vld(rd_vld), .bank_cs(bank_cs)
  );

  // reference model
  logic [15:0] model [int];
  logic [11:0] cur_addr = '0;
  bit          held = 0;
  logic [7:0]  held_lo = '0;
  logic [7:0]  exp_q [$];
  string       req_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] bank_bit(input logic [11:0] a);
    return 4'b0001 << a[11:10];
  endfunction

  // monitor: pop and compare read results
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) chk(0, "R7/R9 unexpected rd_vld", rd_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk(rd_data == e, r, rd_data, e);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    addr_ld = 0; wr_stb = 0; rd_stb = 0;
  endtask

  task automatic load(input logic [11:0] a);
    @(negedge clk);
    addr_ld = 1; wr_stb = 0; rd_stb = 0; addr_in = a;
    cur_addr = a;
  endtask

  // one byte write; returns whether a store follows
  task automatic wbyte(input bit hi, input logic [7:0] d, output bit stores);
    @(negedge clk);
    addr_ld = 0; rd_stb = 0; wr_stb = 1; byte_hi = hi; wr_data = d;
    stores = 0;
    if (!hi) begin held = 1; held_lo = d; end
    else if (held) begin
      model[cur_addr] = {d, held_lo};
      held = 0; stores = 1;
    end
  endtask

  task automatic rbyte(input bit hi, input string req);
    @(negedge clk);
    addr_ld = 0; wr_stb = 0; rd_stb = 1; byte_hi = hi;
    exp_q.push_back(hi ? model[cur_addr][15:8] : model[cur_addr][7:0]);
    req_q.push_back(req);
    #2 chk(bank_cs == bank_bit(cur_addr), "R8 read bank select", bank_cs, bank_bit(cur_addr));
  endtask

  // full word write with check of the store cycle
  task automatic wword(input logic [15:0] w, input string req);
    bit s;
    wbyte(0, w[7:0], s);
    #2 chk(bank_cs == 4'b0, "R3 no select on lower byte", bank_cs, 0);
    wbyte(1, w[15:8], s);
    idle();
    #2 chk(bank_cs == (s ? bank_bit(cur_addr) : 4'b0), req, bank_cs, bank_bit(cur_addr));
  endtask

  initial begin
    #(200000 * 20);
    chk(0, "watchdog", 0, 1);
    done = 1;
  end

  initial begin
    bit s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_vld == 0, "R1 rd_vld at reset", rd_vld, 0);
    chk(rd_data == 0, "R1 rd_data at reset", rd_data, 0);
    chk(bank_cs == 0, "R1 bank_cs at reset", bank_cs, 0);
    rst_n = 1;

    // R1: upper byte with nothing held after reset
    load(12'h005);
    wbyte(1, 8'hAA, s);
    idle();
    #2 chk(bank_cs == 0, "R1 no store after reset", bank_cs, 0);

    // R4 R7 basic word, bank 0
    wword(16'h1234, "R4 store select bank0");
    rbyte(0, "R7 low byte");
    rbyte(1, "R7 high byte");
    idle();

    // R2 bank decode: same offset in bank 3
    load(12'hC05);
    wword(16'hBEEF, "R4 store select bank3");
    rbyte(1, "R2 bank3 high");
    load(12'h005);
    rbyte(0, "R2 bank0 unaffected low");
    rbyte(1, "R2 bank0 unaffected high");
    load(12'h7FF);
    wword(16'hC3A5, "R2 store select bank1 top offset");
    load(12'h800);
    wword(16'h5A0F, "R2 store select bank2 offset0");
    load(12'h7FF);
    rbyte(0, "R2 bank1 top offset");
    load(12'h800);
    rbyte(1, "R2 bank2 offset0");
    idle();

    // R3 lower byte alone does not store
    load(12'h005);
    wbyte(0, 8'h77, s);
    idle();
    #2 chk(bank_cs == 0, "R3 no store", bank_cs, 0);
    rbyte(0, "R3 memory unchanged");
    // R6 second lower byte replaces first
    wbyte(0, 8'h56, s);
    wbyte(1, 8'h9A, s);
    idle();
    #2 chk(bank_cs == 4'b0001, "R6 store after restart", bank_cs, 4'b0001);
    rbyte(0, "R6 replaced low byte");
    rbyte(1, "R6 high byte");
    idle();

    // R5 upper byte alone ignored
    load(12'hC05);
    wbyte(1, 8'h55, s);
    idle();
    #2 chk(bank_cs == 0, "R5 no store", bank_cs, 0);
    rbyte(1, "R5 memory unchanged");
    idle();

    // R9 read strobe in the store cycle
    load(12'h913);
    wbyte(0, 8'h11, s);
    wbyte(1, 8'h22, s);
    @(negedge clk);
    wr_stb = 0; rd_stb = 1; byte_hi = 0;
    #2 chk(bank_cs == 4'b0100, "R9 only storing bank selected", bank_cs, 4'b0100);
    idle();
    #2 chk(rd_vld == 0, "R9 no rd_vld", rd_vld, 0);
    rbyte(1, "R9 stored word intact");
    idle();

    // back-to-back pattern over all banks
    for (int i = 0; i < 8; i++) begin
      load(12'((i * 517) % 4096));
      wword(16'(i * 16'h1111 + 16'h0101), "R4 pattern store");
    end
    for (int i = 0; i < 8; i++) begin
      load(12'((i * 517) % 4096));
      rbyte(0, "R7 pattern low");
      rbyte(1, "R7 pattern high");
    end
    idle();
    idle();
    chk(exp_q.size() == 0, "R7 missing read results", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule